// File: doc/BRIEF.md
# Half-Bridge Gate Enable Decoder

This block turns per-output control bits into gate enables for two half-bridge legs. Each leg has a two-bit side code that asks for the high-side switch, the low-side switch, or neither. A third setting hands the leg to a PWM pin when that leg's PWM select bit is set. In that case the high side conducts while the pin is high and the low side conducts while it is low. A swap bit makes every leg follow the first PWM pin instead of its own.

A mode input separates standby from active operation. In standby every gate is forced off and the PWM synchronizer history is cleared. A per-leg fault-off input overrides everything else for that leg. An output interlock ensures that a leg never drives both of its switches at once. The PWM pins are asynchronous, so each one passes through two synchronizing flops. All gate enables leave the block from registers.

Top module: `hbridge_out_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `hs_gate` and `ls_gate` is 0, and the outputs clear as soon as `rst_n` falls, without waiting for a clock edge.
- R2: In active mode, leg i takes its code from `side_code[2i+1:2i]`. Bit 2i+1 requests the high side and bit 2i requests the low side. Code 00 turns both switches off, 01 turns on only the low side, and 10 turns on only the high side. A change to the code reaches the gates at the first rising edge after it.
- R3: A leg with code 11 and `pwm_sel[i]`=0 has both switches off.
- R4: A leg with code 11 and `pwm_sel[i]`=1 drives the high side equal to its routed PWM pin and the low side equal to that pin's complement. A pin level that is stable before rising edge k appears at the gates after edge k+2.
- R5: `pwm_sel[i]` has no effect on a leg whose code is 00, 01 or 10.
- R6: With `pwm_swap`=0, leg i follows `pwm_pin[i]`. With `pwm_swap`=1, every leg follows `pwm_pin[0]`.
- R7: For no leg are `hs_gate[i]` and `ls_gate[i]` ever 1 in the same cycle.
- R8: With `mode_active`=0, all gates are off one edge later, whatever the other inputs are. The synchronizer is held at 0 during standby. When the mode rises before edge k with a PWM-driven pin held high, the leg shows the low side after edges k and k+1 and the high side after edge k+2.
- R9: `fault_off[i]`=1 turns off both switches of leg i at the next edge and leaves the other legs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_active | input | 1 | 1 = active, 0 = standby |
| side_code | input | 2*NUM_LEGS | Per-leg {high, low} side request code |
| pwm_sel | input | NUM_LEGS | Per-leg PWM select for code 11 |
| pwm_swap | input | 1 | Route every leg to PWM pin 0 |
| pwm_pin | input | NUM_LEGS | Asynchronous PWM pins |
| fault_off | input | NUM_LEGS | Per-leg forced-off request |
| hs_gate | output | NUM_LEGS | High-side gate enables |
| ls_gate | output | NUM_LEGS | Low-side gate enables |

## Verification
Several internal faults would show at the gate pins within the next edge: a wrong decode entry, a missing fault override or a broken interlock. A fault in the synchronizer or in its standby clear would show differently, as a PWM edge arriving one cycle early or late, or as a stale high level right after the mode rises. Checks that count edges after a pin change or a mode change expose these timing faults. A routing mistake shows only with the swap bit set and the two pins at different levels, so the vectors drive the pins apart.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    SIDE_OFF  = 2'b00,
    SIDE_LOW  = 2'b01,
    SIDE_HIGH = 2'b10,
    SIDE_PWM  = 2'b11
  } side_code_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_pair_t;

  localparam gate_pair_t GATES_OFF = '{hs: 1'b0, ls: 1'b0};

endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_q = chain_q[STAGES-1];

endmodule

// File: rtl/hb_pwm_sync.sv
module hb_pwm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = clr ? '0 : din;
    end else begin : g_next
      always_comb stage_d[s] = clr ? '0 : stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hb_pwm_route.sv
module hb_pwm_route #(
  parameter int NUM_LEGS = 2
) (
  input  logic                swap,
  input  logic [NUM_LEGS-1:0] pwm_in,
  output logic [NUM_LEGS-1:0] pwm_out
);

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    always_comb pwm_out[i] = swap ? pwm_in[0] : pwm_in[i];
  end

endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] code,
  input  logic       sel,
  input  logic       pwm,
  input  logic       fault,
  output logic       hs,
  output logic       ls
);

  gate_pair_t req;
  gate_pair_t gate_d;
  gate_pair_t gate_q;
  side_code_e code_e;

  assign code_e = side_code_e'(code);

  always_comb begin
    req = GATES_OFF;
    if (active && !fault) begin
      unique case (code_e)
        SIDE_LOW:  req.ls = 1'b1;
        SIDE_HIGH: req.hs = 1'b1;
        SIDE_PWM:  if (sel) begin
                     req.hs = pwm;
                     req.ls = !pwm;
                   end
        default:   req = GATES_OFF;
      endcase
    end
  end

  // Interlock: a conflicting request resolves to both switches off.
  always_comb begin
    gate_d = (req.hs && req.ls) ? GATES_OFF : req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GATES_OFF;
    else        gate_q <= gate_d;
  end

  assign hs = gate_q.hs;
  assign ls = gate_q.ls;

endmodule

// File: rtl/hbridge_out_ctrl.sv
module hbridge_out_ctrl #(
  parameter int NUM_LEGS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_active,
  input  logic [2*NUM_LEGS-1:0] side_code,
  input  logic [NUM_LEGS-1:0]   pwm_sel,
  input  logic                  pwm_swap,
  input  logic [NUM_LEGS-1:0]   pwm_pin,
  input  logic [NUM_LEGS-1:0]   fault_off,
  output logic [NUM_LEGS-1:0]   hs_gate,
  output logic [NUM_LEGS-1:0]   ls_gate
);

  logic                rst_n_q;
  logic [NUM_LEGS-1:0] pwm_synced;
  logic [NUM_LEGS-1:0] pwm_routed;

  hb_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_q (rst_n_q)
  );

  hb_pwm_sync #(.WIDTH(NUM_LEGS), .STAGES(SYNC_STAGES)) u_pwm_sync (
    .clk   (clk),
    .rst_n (rst_n_q),
    .clr   (!mode_active),
    .din   (pwm_pin),
    .dout  (pwm_synced)
  );

  hb_pwm_route #(.NUM_LEGS(NUM_LEGS)) u_route (
    .swap    (pwm_swap),
    .pwm_in  (pwm_synced),
    .pwm_out (pwm_routed)
  );

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    hb_leg u_leg (
      .clk    (clk),
      .rst_n  (rst_n_q),
      .active (mode_active),
      .code   (side_code[2*i+1:2*i]),
      .sel    (pwm_sel[i]),
      .pwm    (pwm_routed[i]),
      .fault  (fault_off[i]),
      .hs     (hs_gate[i]),
      .ls     (ls_gate[i])
    );
  end

endmodule

// File: rtl/hb_chk.sv
module hb_chk #(
  parameter int NUM_LEGS = 2
) (
  input logic                  clk,
  input logic                  rst_n_q,
  input logic                  mode_active,
  input logic [2*NUM_LEGS-1:0] side_code,
  input logic [NUM_LEGS-1:0]   pwm_sel,
  input logic [NUM_LEGS-1:0]   fault_off,
  input logic [NUM_LEGS-1:0]   hs_gate,
  input logic [NUM_LEGS-1:0]   ls_gate
);

  a_r7_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n_q)
    (hs_gate & ls_gate) == '0);

  a_r8_standby_off: assert property (@(posedge clk) disable iff (!rst_n_q)
    !mode_active |=> (hs_gate == '0) && (ls_gate == '0));

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    a_r9_fault_off: assert property (@(posedge clk) disable iff (!rst_n_q)
      fault_off[i] |=> !hs_gate[i] && !ls_gate[i]);

    a_r2_low_side: assert property (@(posedge clk) disable iff (!rst_n_q)
      (mode_active && !fault_off[i] && side_code[2*i+1:2*i] == 2'b01)
      |=> ls_gate[i] && !hs_gate[i]);

    a_r2_high_side: assert property (@(posedge clk) disable iff (!rst_n_q)
      (mode_active && !fault_off[i] && side_code[2*i+1:2*i] == 2'b10)
      |=> hs_gate[i] && !ls_gate[i]);

    a_r3_pwm_unselected: assert property (@(posedge clk) disable iff (!rst_n_q)
      (side_code[2*i+1:2*i] == 2'b11 && !pwm_sel[i])
      |=> !hs_gate[i] && !ls_gate[i]);
  end

endmodule

bind hbridge_out_ctrl hb_chk #(.NUM_LEGS(NUM_LEGS)) u_chk (
  .clk         (clk),
  .rst_n_q     (rst_n_q),
  .mode_active (mode_active),
  .side_code   (side_code),
  .pwm_sel     (pwm_sel),
  .fault_off   (fault_off),
  .hs_gate     (hs_gate),
  .ls_gate     (ls_gate)
);

// File: tb/hbridge_out_ctrl_tb.sv
`timescale 1ns/1ps
module hbridge_out_ctrl_tb;

  localparam int NL = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_active;
  logic [2*NL-1:0] side_code;
  logic [NL-1:0] pwm_sel;
  logic          pwm_swap;
  logic [NL-1:0] pwm_pin;
  logic [NL-1:0] fault_off;
  logic [NL-1:0] hs_gate;
  logic [NL-1:0] ls_gate;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  hbridge_out_ctrl #(.NUM_LEGS(NL)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_active (mode_active),
    .side_code   (side_code),
    .pwm_sel     (pwm_sel),
    .pwm_swap    (pwm_swap),
    .pwm_pin     (pwm_pin),
    .fault_off   (fault_off),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate)
  );

  // Vector fields: [15] mode, [14] swap, [13:12] sel, [11:8] code,
  // [7:6] pwm, [5:4] fault, [3:2] expected hs, [1:0] expected ls.
  localparam int NVEC = 14;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'b11, 4'b1111, 2'b11, 2'b00, 2'b00, 2'b00}, // R8 standby
    {1'b1, 1'b0, 2'b00, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00}, // R2 code 00
    {1'b1, 1'b0, 2'b00, 4'b0110, 2'b00, 2'b00, 2'b01, 2'b10}, // R2 low/high
    {1'b1, 1'b0, 2'b00, 4'b1001, 2'b00, 2'b00, 2'b10, 2'b01}, // R2 high/low
    {1'b1, 1'b0, 2'b00, 4'b1111, 2'b11, 2'b00, 2'b00, 2'b00}, // R3
    {1'b1, 1'b0, 2'b11, 4'b1111, 2'b01, 2'b00, 2'b01, 2'b10}, // R4
    {1'b1, 1'b0, 2'b11, 4'b1111, 2'b10, 2'b00, 2'b10, 2'b01}, // R4
    {1'b1, 1'b1, 2'b11, 4'b1111, 2'b01, 2'b00, 2'b11, 2'b00}, // R6 swap, pin0 high
    {1'b1, 1'b1, 2'b11, 4'b1111, 2'b10, 2'b00, 2'b00, 2'b11}, // R6 swap, pin0 low
    {1'b1, 1'b0, 2'b11, 4'b0110, 2'b11, 2'b00, 2'b01, 2'b10}, // R5
    {1'b1, 1'b0, 2'b11, 4'b0000, 2'b11, 2'b00, 2'b00, 2'b00}, // R5
    {1'b1, 1'b0, 2'b00, 4'b1001, 2'b00, 2'b01, 2'b10, 2'b00}, // R9 leg0 faulted
    {1'b1, 1'b0, 2'b11, 4'b1111, 2'b11, 2'b10, 2'b01, 2'b00}, // R9 leg1 faulted
    {1'b0, 1'b0, 2'b00, 4'b0110, 2'b00, 2'b00, 2'b00, 2'b00}  // R8 standby
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {hs,ls}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_active = 1'b0; side_code = '0; pwm_sel = '0;
    pwm_swap = 1'b0; pwm_pin = '0; fault_off = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {hs_gate, ls_gate}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: apply a vector, let the synchronizer settle, compare.
    for (int v = 0; v < NVEC; v++) begin
      mode_active = VEC[v][15];
      pwm_swap    = VEC[v][14];
      pwm_sel     = VEC[v][13:12];
      side_code   = VEC[v][11:8];
      pwm_pin     = VEC[v][7:6];
      fault_off   = VEC[v][5:4];
      repeat (4) @(negedge clk);
      check($sformatf("table vector %0d (R2 R3 R4 R5 R6 R8 R9)", v),
            {hs_gate, ls_gate}, VEC[v][3:0]);
    end

    // R2: one-edge latency of a code change.
    mode_active = 1'b1; pwm_sel = '0; fault_off = '0; side_code = 4'b0000;
    repeat (2) @(negedge clk);
    side_code = 4'b0110;
    @(negedge clk);
    check("R2 latency one edge", {hs_gate, ls_gate}, 4'b0110);

    // R4: PWM pin edge reaches the gate after edge k+2.
    side_code = 4'b0011; pwm_sel = 2'b01; pwm_swap = 1'b0; pwm_pin = 2'b00;
    repeat (4) @(negedge clk);
    pwm_pin = 2'b01;
    @(negedge clk);
    check("R4 after edge k", {hs_gate, ls_gate}, 4'b0001);
    @(negedge clk);
    check("R4 after edge k+1", {hs_gate, ls_gate}, 4'b0001);
    @(negedge clk);
    check("R4 after edge k+2", {hs_gate, ls_gate}, 4'b0100);

    // R8: synchronizer cleared in standby, refills after the mode rises.
    mode_active = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 standby off", {hs_gate, ls_gate}, 4'b0000);
    mode_active = 1'b1;
    @(negedge clk);
    check("R8 wake edge k", {hs_gate, ls_gate}, 4'b0001);
    @(negedge clk);
    check("R8 wake edge k+1", {hs_gate, ls_gate}, 4'b0001);
    @(negedge clk);
    check("R8 wake edge k+2", {hs_gate, ls_gate}, 4'b0100);

    // R7: fast PWM toggling on both legs, never both switches on.
    begin
      int overlaps = 0;
      side_code = 4'b1111; pwm_sel = 2'b11;
      for (int c = 0; c < 40; c++) begin
        pwm_pin = c[1:0];
        @(negedge clk);
        if ((hs_gate & ls_gate) != '0) overlaps++;
      end
      check("R7 no overlap count", overlaps[3:0], 4'd0);
    end

    // R1: asynchronous clear in the middle of a cycle.
    side_code = 4'b0110; pwm_sel = '0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear", {hs_gate, ls_gate}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 after reset release", {hs_gate, ls_gate}, 4'b0110);

    finish_run();
  end

endmodule